// File: doc/BRIEF.md
# Gated-Reset Bi-Quinary Decade Counter

A four-bit counter made of two stages: a divide-by-two cell and a divide-by-five cell. Each cell steps on a falling edge of its own count input. Both count inputs arrive asynchronously. Each passes through a synchronizer into one system clock, and a falling-edge detector turns it into a one-cycle step pulse. All state is therefore synchronous to `clk`.

Two paired controls override the count. Both clear inputs high forces the output to zero. Both preset inputs high forces it to nine, and the preset wins over the clear. A forced value is shown at once and is also written into the state, so counting resumes from it after release.

A two-bit strap selects how the cells are wired:
- **Split mode:** the cells count apart, each from its own input.
- **Decade mode:** the low bit going from 1 to 0 steps the upper cell. The output then counts 0 to 9 in BCD.
- **Bi-quinary mode:** the upper cell's top bit going from 1 to 0 toggles the low bit. This gives a symmetric divide-by-ten on the low bit.

Top module: `bq_decade_counter`

## Requirements
- R1: While `rst_n` is low, and after it rises with no count edge, `q` is 4'b0000.
- R2: In split mode (`mode_sel` 2'b00 or 2'b11), each falling edge on `cnt_a_in` toggles `q[0]`. A falling edge on `cnt_b_in` does not touch `q[0]`.
- R3: In split mode, each falling edge on `cnt_b_in` steps `q[3:1]` through 000, 001, 010, 011, 100 and back to 000, with `q[3]` the most significant bit.
- R4: While `zero_a` and `zero_b` are both high and the preset pair is not both high, `q` reads 4'b0000 in the same cycle. After release, counting resumes from zero.
- R5: While `nine_a` and `nine_b` are both high, `q` reads 4'b1001 in the same cycle, whatever the clear inputs are. After release, counting resumes from nine.
- R6: While either force condition holds, falling edges on the count inputs have no effect on `q`.
- R7: In decade mode (`mode_sel` 2'b01), falling edges on `cnt_a_in` make `q` count 0 to 9 in BCD and wrap to 0. `q[3:1]` steps in the same clock cycle in which `q[0]` goes from 1 to 0. `cnt_b_in` is ignored.
- R8: In bi-quinary mode (`mode_sel` 2'b10), falling edges on `cnt_b_in` step `q[3:1]`. `q[0]` toggles in the same cycle in which `q[3]` goes from 1 to 0. `cnt_a_in` is ignored. Over ten edges starting from zero, `q[0]` is high after exactly five of them.
- R9: Only falling edges count; rising edges are ignored. A falling edge held for at least three clock cycles shows on `q` by the fourth rising clock edge.
- R10: `q[3:1]` never holds a value above 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_in | input | 1 | Count input of the divide-by-two cell (asynchronous) |
| cnt_b_in | input | 1 | Count input of the divide-by-five cell (asynchronous) |
| zero_a | input | 1 | Clear-to-zero control, first of pair |
| zero_b | input | 1 | Clear-to-zero control, second of pair |
| nine_a | input | 1 | Preset-to-nine control, first of pair |
| nine_b | input | 1 | Preset-to-nine control, second of pair |
| mode_sel | input | 2 | Wiring strap: 00/11 split, 01 decade, 10 bi-quinary |
| q | output | 4 | Count value {upper cell, low bit} |

## Verification
The assertions take three things for granted about the inputs:
- The strap changes rarely and never in the same cycle as a count step. This is why the cascade checks require the mode to have held for two sampled cycles.
- Each count input level is held long enough to pass the synchronizer.
- The force controls are sampled by the same clock as the rest of the logic.

The stimulus keeps to these rules. Each count pulse stays low, then high, for four clock periods. Mode changes happen only with the count inputs idle high. Random force pulses are placed between count pulses.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int HI_MOD = 5;
  localparam int HI_W   = $clog2(HI_MOD);
  localparam int Q_W    = HI_W + 1;
  localparam logic [HI_W-1:0] HI_MAX = HI_W'(HI_MOD - 1);
  localparam logic [Q_W-1:0]  Q_NINE = {HI_MAX, 1'b1};

  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'b00,
    MODE_DEC    = 2'b01,
    MODE_BQ     = 2'b10,
    MODE_SPLITX = 2'b11
  } wiring_t;
endpackage

// File: rtl/bq_edge_sync.sv
module bq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign fall = prev & ~sh[STAGES-1];
endmodule

// File: rtl/bq_lo_cell.sv
module bq_lo_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic step,
  output logic bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bit_q <= 1'b0;
    else if (load) bit_q <= load_val;
    else if (step) bit_q <= ~bit_q;
  end
endmodule

// File: rtl/bq_hi_cell.sv
module bq_hi_cell import bq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HI_W-1:0] load_val,
  input  logic            step,
  output logic [HI_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= (cnt == HI_MAX) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter import bq_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_a_in,
  input  logic           cnt_b_in,
  input  logic           zero_a,
  input  logic           zero_b,
  input  logic           nine_a,
  input  logic           nine_b,
  input  logic [1:0]     mode_sel,
  output logic [Q_W-1:0] q
);
  wiring_t         wiring;
  logic            fall_a, fall_b;
  logic            force_nine, force_zero, forcing;
  logic            evt_a, evt_b, lo_step, hi_step;
  logic            lo_q;
  logic [HI_W-1:0] hi_q;
  logic [Q_W-1:0]  force_val;

  assign wiring = wiring_t'(mode_sel);

  bq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .din(cnt_a_in), .fall(fall_a));
  bq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .din(cnt_b_in), .fall(fall_b));

  // preset pair outranks the clear pair
  assign force_nine = nine_a & nine_b;
  assign force_zero = zero_a & zero_b & ~force_nine;
  assign forcing    = force_nine | force_zero;
  assign force_val  = force_nine ? Q_NINE : '0;

  // route step pulses by strap; cascades use same-cycle carries
  always_comb begin
    evt_a   = ~forcing & fall_a & (wiring != MODE_BQ);
    evt_b   = ~forcing & fall_b & (wiring != MODE_DEC);
    hi_step = evt_b | ((wiring == MODE_DEC) & evt_a & lo_q);
    lo_step = evt_a | ((wiring == MODE_BQ) & evt_b & (hi_q == HI_MAX));
  end

  bq_lo_cell u_lo (
    .clk(clk), .rst_n(rst_n), .load(forcing), .load_val(force_val[0]),
    .step(lo_step), .bit_q(lo_q));

  bq_hi_cell u_hi (
    .clk(clk), .rst_n(rst_n), .load(forcing), .load_val(force_val[Q_W-1:1]),
    .step(hi_step), .cnt(hi_q));

  assign q = forcing ? force_val : {hi_q, lo_q};
endmodule

// File: rtl/bq_decade_counter_chk.sv
module bq_decade_counter_chk import bq_pkg::*; (
  input logic           clk,
  input logic           rst_n,
  input logic           zero_a,
  input logic           zero_b,
  input logic           nine_a,
  input logic           nine_b,
  input logic [1:0]     mode_sel,
  input logic [Q_W-1:0] q
);
  logic f_nine, f_zero, f_any;
  assign f_nine = nine_a & nine_b;
  assign f_zero = zero_a & zero_b & ~f_nine;
  assign f_any  = f_nine | f_zero;

  // R10
  hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[Q_W-1:1] <= HI_MAX);
  // R5
  nine_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_nine |-> q == Q_NINE);
  // R4
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_zero |-> q == '0);
  // R5
  nine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(f_nine) && !f_any) |-> q == Q_NINE);
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(f_zero) && !f_any) |-> q == '0);
  // R6
  force_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(f_any) && f_any && $stable({nine_a, nine_b})) |-> $stable(q));
  // R7
  dec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && !f_any && !$past(f_any)
     && !$stable(q[Q_W-1:1])) |-> ($past(q[0]) && !q[0]));
  // R8
  bq_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && $past(mode_sel) == 2'b10 && !f_any && !$past(f_any)
     && !$stable(q[0])) |-> ($past(q[Q_W-1]) && !q[Q_W-1]));
endmodule

bind bq_decade_counter bq_decade_counter_chk u_chk (.*);

// File: tb/test_bq_decade_counter.sv
module test_bq_decade_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_a_in = 1'b1, cnt_b_in = 1'b1;
  logic       zero_a = 1'b0, zero_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] q;

  int total = 0;
  int bad   = 0;
  int m_up  = 0;
  int m_lo  = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bq_decade_counter i_bq_decade_counter (
    .clk(clk), .rst_n(rst_n), .cnt_a_in(cnt_a_in), .cnt_b_in(cnt_b_in),
    .zero_a(zero_a), .zero_b(zero_b), .nine_a(nine_a), .nine_b(nine_b),
    .mode_sel(mode_sel), .q(q));

  function automatic logic [3:0] model_q();
    return {3'(m_up), 1'(m_lo)};
  endfunction

  function automatic void model_fall_a();
    if (mode_sel == 2'b10) return;
    if (mode_sel == 2'b01 && m_lo == 1) m_up = (m_up + 1) % 5;
    m_lo ^= 1;
  endfunction

  function automatic void model_fall_b();
    if (mode_sel == 2'b01) return;
    if (mode_sel == 2'b10 && m_up == 4) m_lo ^= 1;
    m_up = (m_up + 1) % 5;
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // falling edge, check, rising edge, check unchanged (R9)
  task automatic pulse(input bit on_b, input string req);
    if (on_b) cnt_b_in = 1'b0; else cnt_a_in = 1'b0;
    cycles(4);
    if (on_b) model_fall_b(); else model_fall_a();
    check(req, model_q());
    if (on_b) cnt_b_in = 1'b1; else cnt_a_in = 1'b1;
    cycles(4);
    check("R9", model_q());
  endtask

  task automatic apply_force(input bit nine, input bit zero, input bit cnt_edge);
    nine_a = nine; nine_b = nine; zero_a = zero; zero_b = zero;
    #1;
    if (nine) begin m_up = 4; m_lo = 1; end
    else if (zero) begin m_up = 0; m_lo = 0; end
    check(nine ? "R5" : "R4", model_q());
    if (cnt_edge) begin
      cnt_a_in = 1'b0; cnt_b_in = 1'b0; cycles(4);
      check("R6", model_q());
      cnt_a_in = 1'b1; cnt_b_in = 1'b1; cycles(4);
    end else cycles(2);
    nine_a = 0; nine_b = 0; zero_a = 0; zero_b = 0;
    cycles(2);
    check(nine ? "R5" : "R4", model_q());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd1234));
    cycles(2);
    check("R1", 4'b0000);
    rst_n = 1'b1;
    cycles(6);
    check("R1", 4'b0000);

    // split mode, directed
    mode_sel = 2'b00;
    pulse(0, "R2");
    pulse(0, "R2");
    for (int i = 0; i < 6; i++) pulse(1, "R3");
    pulse(1, "R2");

    // forces and priority
    apply_force(0, 1, 1);
    apply_force(1, 0, 1);
    apply_force(1, 1, 0);
    pulse(0, "R5");
    apply_force(0, 1, 0);

    // decade mode: full sequence from zero, then B ignored
    mode_sel = 2'b01;
    cycles(2);
    for (int i = 0; i < 10; i++) begin
      pulse(0, "R7");
      total++;
      if (q !== 4'((i + 1) % 10)) begin
        bad++;
        $display("FAIL R7: q=%0d expected=%0d", q, (i + 1) % 10);
      end
    end
    pulse(1, "R7");
    apply_force(1, 0, 0);
    pulse(0, "R7");

    // bi-quinary mode: duty over ten edges from zero
    apply_force(0, 1, 0);
    mode_sel = 2'b10;
    cycles(2);
    hi_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1, "R8");
      if (q[0]) hi_cnt++;
    end
    total++;
    if (hi_cnt != 5) begin
      bad++;
      $display("FAIL R8: high_count=%0d expected=5", hi_cnt);
    end
    pulse(0, "R8");

    // random mix across modes
    for (int i = 0; i < 300; i++) begin
      int pick;
      if (i % 100 == 0) begin
        mode_sel = 2'($urandom_range(0, 3));
        cycles(2);
      end
      pick = $urandom_range(0, 9);
      if (pick < 4)       pulse(0, "R2/R7");
      else if (pick < 8)  pulse(1, "R3/R8");
      else if (pick == 8) apply_force(1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)));
      else                apply_force(1'b1, 1'($urandom_range(0, 1)), 1'b0);
      total++;
      if (q[3:1] > 3'b100) begin
        bad++;
        $display("FAIL R10: q_hi=%b expected<=100", q[3:1]);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule